// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block handles the interrupt requests of five sources: two external pins, two timers and a serial port. It gates each request with a global enable and a per-source enable. It assigns each source to a low or a high priority class. It picks one winner per cycle and presents that winner's handler address to the processor core.

The processor confirms that it is taking the request by pulsing `ack`. At that point the block records the winner's class as active. It also clears the winner's edge flag or timer flag. A pulse on `reti` ends the most recent active handler.

The two external pins each have their own trigger type:
- **Level mode:** the pin requests service for as long as it is held low.
- **Edge mode:** the pin is sampled on each machine-cycle tick, and a high sample followed by a low sample latches a flag.

Top module: `irq_ctrl`

## Requirements
- R1: While `glb_en` is 0, `irq_req` stays 0 whatever the sources and per-source enables do. While `glb_en` is 1, a source can request only when its bit of `src_en` is 1.
- R2: Source index i maps to bit i of `src_en`, `src_prio` and the winner encoding: 0 = external 0, 1 = timer 0, 2 = external 1, 3 = timer 1, 4 = serial. While `irq_req` is 1, `irq_vec` equals 0003h + 8·i for the winning index i, so the values are 0003h, 000Bh, 0013h, 001Bh and 0023h.
- R3: A pending source whose `src_prio` bit is 1 (high class) wins over every low-class source. Within one class, the lowest index wins.
- R4: The current state limits which requests `irq_req` shows. With no handler active, any pending request is shown. With a low-class handler active, only high-class requests are shown. With a high-class handler active, nothing is shown.
- R5: When `ext_edge[k]` is 0, external k requests while `ext_pin_n[k]` is 0. An acknowledge leaves that request in place.
- R6: When `ext_edge[k]` is 1, `ext_flag[k]` becomes 1 in the clock after a `mc_tick` cycle. This happens when the pin was 1 at the previous tick and is 0 at this tick. A falling pin with no tick in between sets nothing. The flag clears in the clock after that source is acknowledged.
- R7: A one-cycle pulse on `tmr_ovf[k]` sets `tmr_flag[k]` in the next clock. The flag holds until timer k is acknowledged, and clears in the clock after the acknowledge.
- R8: The serial request follows `ser_flag` directly and is never cleared by an acknowledge.
- R9: In the clock after `ack` while `irq_req` is 1, `act_lvl` sets the bit of the winner's class (bit 0 low, bit 1 high). In the clock after `reti`, the high bit clears if it is set; otherwise the low bit clears.
- R10: After reset, `act_lvl`, `ext_flag` and `tmr_flag` are all 0, and each edge sampler holds a 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mc_tick | input | 1 | Machine-cycle sampling strobe for the external pins |
| glb_en | input | 1 | Global interrupt enable |
| src_en | input | 5 | Per-source enables, indexed as in R2 |
| src_prio | input | 5 | Per-source class: 1 high, 0 low |
| ext_edge | input | 2 | External trigger type: 1 falling edge, 0 low level |
| ext_pin_n | input | 2 | External request pins, active low |
| tmr_ovf | input | 2 | Timer overflow pulses |
| ser_flag | input | 1 | Serial interrupt flag, level |
| ack | input | 1 | Processor takes the presented request |
| reti | input | 1 | Processor returns from the current handler |
| irq_req | output | 1 | A request is presented |
| irq_vec | output | 16 | Handler address of the winner |
| act_lvl | output | 2 | Active classes: bit 0 low, bit 1 high |
| ext_flag | output | 2 | Latched falling-edge flags |
| tmr_flag | output | 2 | Latched timer flags |

## Verification
`irq_req` and `irq_vec` are combinational from the inputs and the registered state. The bench therefore drives each input one time unit after a rising edge and reads these outputs at the following falling edge of the same cycle.

Flags and `act_lvl` are registered, so a tick, an overflow pulse, `ack` or `reti` driven in one cycle shows up one clock later. The bench steps exactly one rising edge past the stimulus before it samples them.

For the case where a pin falls without a tick, the bench holds the pin low for several cycles with no tick and checks that the flag stays 0.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NSRC       = 5;
    localparam int NEXT       = 2;
    localparam int NTMR       = 2;
    localparam int IDXW       = $clog2(NSRC);
    localparam int VECW       = 16;
    localparam int VEC_BASE   = 3;
    localparam int VEC_STRIDE = 8;

    typedef struct packed {
        logic            hi;
        logic            lo;
        logic [NTMR-1:0] tmr;
    } ctl_state_t;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic edge_mode,
    input  logic pin_n,
    input  logic clr,
    output logic flag
);
    typedef struct packed {
        logic prev;
        logic flag;
    } ed_t;

    ed_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr)
            st_d.flag = 1'b0;
        if (tick) begin
            st_d.prev = pin_n;
            if (edge_mode && st_q.prev && !pin_n)
                st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev <= 1'b1;
            st_q.flag <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int NSRC = 5,
    localparam int IDXW = $clog2(NSRC)
) (
    input  logic [NSRC-1:0] pend,
    input  logic [NSRC-1:0] prio,
    output logic            hi_valid,
    output logic [IDXW-1:0] hi_idx,
    output logic            lo_valid,
    output logic [IDXW-1:0] lo_idx
);
    always_comb begin
        hi_valid = 1'b0;
        lo_valid = 1'b0;
        hi_idx   = '0;
        lo_idx   = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i] && prio[i]) begin
                hi_valid = 1'b1;
                hi_idx   = IDXW'(i);
            end
            if (pend[i] && !prio[i]) begin
                lo_valid = 1'b1;
                lo_idx   = IDXW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mc_tick,
    input  logic             glb_en,
    input  logic [NSRC-1:0]  src_en,
    input  logic [NSRC-1:0]  src_prio,
    input  logic [NEXT-1:0]  ext_edge,
    input  logic [NEXT-1:0]  ext_pin_n,
    input  logic [NTMR-1:0]  tmr_ovf,
    input  logic             ser_flag,
    input  logic             ack,
    input  logic             reti,
    output logic             irq_req,
    output logic [VECW-1:0]  irq_vec,
    output logic [1:0]       act_lvl,
    output logic [NEXT-1:0]  ext_flag,
    output logic [NTMR-1:0]  tmr_flag
);
    localparam int SER_IDX = NSRC - 1;

    ctl_state_t st_d, st_q;

    logic [NSRC-1:0] src_raw;
    logic [NSRC-1:0] pend;
    logic [NEXT-1:0] ext_clr;
    logic            hi_valid, lo_valid;
    logic [IDXW-1:0] hi_idx, lo_idx, win_idx;
    logic            win_hi;
    logic            allow;
    logic            take;

    for (genvar k = 0; k < NEXT; k++) begin : g_ext
        irq_edge_det u_ed (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (mc_tick),
            .edge_mode (ext_edge[k]),
            .pin_n     (ext_pin_n[k]),
            .clr       (ext_clr[k]),
            .flag      (ext_flag[k])
        );
        assign src_raw[2*k] = ext_edge[k] ? ext_flag[k] : ~ext_pin_n[k];
        assign ext_clr[k]   = take && (win_idx == IDXW'(2*k));
    end

    for (genvar k = 0; k < NTMR; k++) begin : g_tmr
        assign src_raw[2*k+1] = st_q.tmr[k];
    end

    assign src_raw[SER_IDX] = ser_flag;
    assign pend = src_raw & src_en & {NSRC{glb_en}};

    irq_arbiter #(.NSRC(NSRC)) u_arb (
        .pend     (pend),
        .prio     (src_prio),
        .hi_valid (hi_valid),
        .hi_idx   (hi_idx),
        .lo_valid (lo_valid),
        .lo_idx   (lo_idx)
    );

    assign win_hi  = hi_valid;
    assign win_idx = hi_valid ? hi_idx : lo_idx;
    assign allow   = !st_q.hi && (!st_q.lo || hi_valid);
    assign irq_req = (hi_valid || lo_valid) && allow;
    assign irq_vec = VECW'(VEC_BASE) + VECW'(win_idx) * VECW'(VEC_STRIDE);
    assign take    = ack && irq_req;

    always_comb begin
        st_d = st_q;
        if (reti) begin
            if (st_q.hi)
                st_d.hi = 1'b0;
            else
                st_d.lo = 1'b0;
        end
        if (take) begin
            if (win_hi)
                st_d.hi = 1'b1;
            else
                st_d.lo = 1'b1;
        end
        for (int k = 0; k < NTMR; k++) begin
            if (take && (win_idx == IDXW'(2*k+1)))
                st_d.tmr[k] = 1'b0;
            if (tmr_ovf[k])
                st_d.tmr[k] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign act_lvl  = {st_q.hi, st_q.lo};
    assign tmr_flag = st_q.tmr;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
    import irq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             glb_en,
    input logic [NSRC-1:0]  src_prio,
    input logic             ack,
    input logic             irq_req,
    input logic [VECW-1:0]  irq_vec,
    input logic [1:0]       act_lvl
);
    logic [VECW-1:0] vec_off;
    logic [VECW-1:0] vec_idx;
    assign vec_off = irq_vec - VECW'(VEC_BASE);
    assign vec_idx = vec_off / VECW'(VEC_STRIDE);

    AST_GLOBAL_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |-> !irq_req); // R1

    AST_VECTOR_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (vec_off % VECW'(VEC_STRIDE) == 0) && (vec_idx < VECW'(NSRC))); // R2

    AST_HIGH_ACTIVE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        act_lvl[1] |-> !irq_req); // R4

    AST_LOW_ACTIVE_HIGH_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (act_lvl[0] && irq_req) |-> src_prio[vec_idx[IDXW-1:0]]); // R4

    AST_ACK_PUSHES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_req && src_prio[vec_idx[IDXW-1:0]]) |=> act_lvl[1]); // R9
endmodule

bind irq_ctrl irq_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .glb_en   (glb_en),
    .src_prio (src_prio),
    .ack      (ack),
    .irq_req  (irq_req),
    .irq_vec  (irq_vec),
    .act_lvl  (act_lvl)
);

// File: tb/irq_ctrl_tb.sv
module irq_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;
    // {glb_en, src_en[4:0], src_prio[4:0], ext_pin_n[1:0], ser_flag, exp_req, exp_vec[15:0]}
    localparam logic [30:0] TBL [NVEC] = '{
        {1'b0, 5'h1F, 5'h00, 2'b00, 1'b1, 1'b0, 16'h0000},  // R1 global off
        {1'b1, 5'h1F, 5'h00, 2'b00, 1'b1, 1'b1, 16'h0003},  // R3 lowest index
        {1'b1, 5'h1E, 5'h00, 2'b00, 1'b0, 1'b1, 16'h0013},  // R1 ext0 masked
        {1'b1, 5'h1F, 5'h04, 2'b00, 1'b0, 1'b1, 16'h0013},  // R3 high wins
        {1'b1, 5'h10, 5'h00, 2'b11, 1'b1, 1'b1, 16'h0023},  // R8 serial
        {1'b1, 5'h1F, 5'h10, 2'b00, 1'b1, 1'b1, 16'h0023},  // R3 serial high
        {1'b1, 5'h15, 5'h14, 2'b00, 1'b1, 1'b1, 16'h0013},  // R3 order in high
        {1'b1, 5'h00, 5'h00, 2'b00, 1'b1, 1'b0, 16'h0000},  // R1 all masked
        {1'b1, 5'h1F, 5'h00, 2'b11, 1'b0, 1'b0, 16'h0000},  // R5 pins idle
        {1'b1, 5'h04, 5'h00, 2'b01, 1'b0, 1'b1, 16'h0013}   // R5 ext1 low
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mc_tick = 1'b0;
    logic        glb_en = 1'b0;
    logic [4:0]  src_en = '0;
    logic [4:0]  src_prio = '0;
    logic [1:0]  ext_edge = '0;
    logic [1:0]  ext_pin_n = 2'b11;
    logic [1:0]  tmr_ovf = '0;
    logic        ser_flag = 1'b0;
    logic        ack = 1'b0;
    logic        reti = 1'b0;
    logic        irq_req;
    logic [15:0] irq_vec;
    logic [1:0]  act_lvl;
    logic [1:0]  ext_flag;
    logic [1:0]  tmr_flag;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .glb_en(glb_en),
        .src_en(src_en), .src_prio(src_prio), .ext_edge(ext_edge),
        .ext_pin_n(ext_pin_n), .tmr_ovf(tmr_ovf), .ser_flag(ser_flag),
        .ack(ack), .reti(reti), .irq_req(irq_req), .irq_vec(irq_vec),
        .act_lvl(act_lvl), .ext_flag(ext_flag), .tmr_flag(tmr_flag)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic mid();
        @(negedge clk);
    endtask

    task automatic pulse_ack();
        ack = 1'b1; step(); ack = 1'b0;
    endtask

    task automatic pulse_reti();
        reti = 1'b1; step(); reti = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        mid();
        check("R10 act_lvl", 32'(act_lvl), 0);
        check("R10 ext_flag", 32'(ext_flag), 0);
        check("R10 tmr_flag", 32'(tmr_flag), 0);
        check("R10 irq_req", 32'(irq_req), 0);

        for (int i = 0; i < NVEC; i++) begin
            step();
            {glb_en, src_en, src_prio, ext_pin_n, ser_flag} = TBL[i][30:17];
            mid();
            check($sformatf("R2 table%0d req", i), 32'(irq_req), 32'(TBL[i][16]));
            if (TBL[i][16])
                check($sformatf("R2 table%0d vec", i), 32'(irq_vec), 32'(TBL[i][15:0]));
        end

        // R5: level request survives an acknowledge
        step();
        glb_en = 1; src_en = 5'h01; src_prio = 0; ext_pin_n = 2'b10; ser_flag = 0;
        pulse_ack();
        mid();
        check("R9 low pushed", 32'(act_lvl), 32'h1);
        check("R5 pin still low, ext_flag untouched", 32'(ext_flag), 0);
        step(); ext_pin_n = 2'b11; pulse_reti();
        mid();
        check("R9 pop low", 32'(act_lvl), 0);

        // R7 timer flag and clear on acknowledge
        step();
        src_en = 5'h12; src_prio = 0; tmr_ovf = 2'b01;
        step(); tmr_ovf = 2'b00;
        mid();
        check("R7 tmr flag set", 32'(tmr_flag), 32'h1);
        check("R7 timer0 vec", 32'(irq_vec), 32'h000B);
        step(); pulse_ack();
        mid();
        check("R7 tmr flag cleared", 32'(tmr_flag), 0);
        check("R9 low active", 32'(act_lvl), 32'h1);

        // R4 low handler blocks low serial, high serial preempts
        step(); ser_flag = 1;
        mid();
        check("R4 low blocks low", 32'(irq_req), 0);
        step(); src_prio = 5'h10;
        mid();
        check("R4 high preempts", 32'(irq_req), 1);
        check("R4 serial vec", 32'(irq_vec), 32'h0023);
        step(); pulse_ack();
        mid();
        check("R9 both active", 32'(act_lvl), 32'h3);
        check("R4 high blocks all", 32'(irq_req), 0);
        step(); pulse_reti();
        mid();
        check("R9 pop high first", 32'(act_lvl), 32'h1);
        check("R8 serial not cleared", 32'(irq_req), 1);
        step(); pulse_reti();
        mid();
        check("R9 pop low", 32'(act_lvl), 0);
        step(); ser_flag = 0; src_prio = 0;

        // R6 edge mode
        step();
        src_en = 5'h01; ext_edge = 2'b01; ext_pin_n = 2'b11;
        mc_tick = 1; step(); mc_tick = 0;
        ext_pin_n = 2'b10;
        step(); step(); step();
        mid();
        check("R6 no tick no flag", 32'(ext_flag), 0);
        check("R6 no tick no req", 32'(irq_req), 0);
        step(); mc_tick = 1; step(); mc_tick = 0;
        mid();
        check("R6 flag set", 32'(ext_flag), 32'h1);
        step(); ext_pin_n = 2'b11;
        mid();
        check("R6 flag holds", 32'(irq_req), 1);
        check("R6 ext0 vec", 32'(irq_vec), 32'h0003);
        step(); pulse_ack();
        mid();
        check("R6 flag cleared", 32'(ext_flag), 0);
        check("R6 no req after clear", 32'(irq_req), 0);
        step(); pulse_reti();

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule